// File: doc/BRIEF.md
# Dual-Port Mailbox Memory with Cross-Port Interrupts

This block is a synchronous two-port memory of 2048 words, 9 bits each. Each side, called left and right, has its own active-low chip enable, read/write select, output enable, address, write data, registered read data, an active-low busy input and an active-low interrupt output. Every location can be read and written from either side. All inputs are sampled on one shared clock edge.

The two top addresses double as mailboxes. A write by the right side to the highest-but-one address (0x7FE) raises the left interrupt. A write by the left side to the highest address (0x7FF) raises the right interrupt. The side that owns an interrupt acknowledges it by accessing its own mailbox with chip enable and output enable both low. The mailbox words remain ordinary storage, so one side leaves a 9-bit message there and the other side reads it. A design that does not use interrupts can treat both words as plain memory.

Each interrupt is held by a two-state machine. `FLAG_IDLE` drives the interrupt output high. `FLAG_RAISED` drives it low. The SET transition runs from `FLAG_IDLE` to `FLAG_RAISED` when a raise occurs. The ACK transition runs from `FLAG_RAISED` back to `FLAG_IDLE` when an acknowledge occurs without a raise in the same cycle. In every other case the machine holds its state.

Top module: `dpmb_top`

## Requirements
- R1: A write occurs when chip enable is low, read/write is low and busy is high; the word is stored at the clock edge. A read occurs when chip enable and output enable are both low; it returns the stored word on the read data port after that edge, one cycle after the address is presented.
- R2: Read data is zero in the cycle after an edge at which chip enable or output enable was high. While chip enable is high, a low read/write stores nothing.
- R3: A write by the right side to address 0x7FE with busy high sets the left flag. `l_int_n` is low after that edge, and the right flag is unaffected.
- R4: The left flag is cleared after an edge at which the left side has chip enable low, output enable low, address 0x7FE and busy high, whatever the level of read/write. An access to 0x7FE with output enable high does not clear it.
- R5: A write by the left side to address 0x7FF with busy high sets the right flag. `r_int_n` is low after that edge.
- R6: The right flag is cleared after an edge at which the right side has chip enable low, output enable low, address 0x7FF and busy high. An access to 0x7FF by the left side does not clear it.
- R7: The words at 0x7FE and 0x7FF hold written data like any other location. Reading a mailbox returns its data, and a read by the non-owning side leaves the flag unchanged.
- R8: While a side's busy input is low, a write from that side is not stored, and that side can neither set nor clear a flag.
- R9: If a flag's set and clear occur at the same edge, the flag ends up set.
- R10: A synchronous active-high reset drives both interrupt outputs high and both read data ports to zero.
- R11: When both sides write the same address at the same edge, the left data is stored. A read at the same edge as a write to the same address returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read/write, low selects write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left registered read data |
| l_busy_n | input | 1 | Left busy, low blocks writes and flag changes |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read/write, low selects write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right registered read data |
| r_busy_n | input | 1 | Right busy, low blocks writes and flag changes |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach is a raise and an acknowledge of the same flag at the same edge. The stimulus gets there by driving a right-side mailbox write and a left-side mailbox read in one cycle, once from the idle state and once with the flag already raised. Busy gating is reached in a similar way: the stimulus lowers busy on exactly the side that would set or clear a flag, then reads the mailbox to show that neither the flag nor the word changed. A behavioural model built on an integer array checks every cycle alongside the directed checks.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 9;
    localparam int NPORTS = 2;
    localparam int PORT_L = 0;
    localparam int PORT_R = 1;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;
endpackage

// File: rtl/dpmb_port_decode.sv
module dpmb_port_decode #(
    parameter int ADDR_W    = dpmb_pkg::ADDR_W,
    parameter int OWN_MBOX  = 0,
    parameter int PEER_MBOX = 1
) (
    input  logic              ce_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              raise_peer,
    output logic              ack_own
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_MBOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_MBOX);

    logic selected;

    always_comb begin
        selected   = !ce_n;
        wr_en      = selected && !rw_n && busy_n;
        rd_en      = selected && !oe_n;
        raise_peer = wr_en && (addr == PEER_A);
        ack_own    = rd_en && busy_n && (addr == OWN_A);
    end
endmodule

// File: rtl/dpmb_flag_fsm.sv
module dpmb_flag_fsm
    import dpmb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic ack,
    output logic int_n
);
    flag_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= FLAG_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FLAG_IDLE:   if (raise)        state_nx = FLAG_RAISED;
            FLAG_RAISED: if (ack && !raise) state_nx = FLAG_IDLE;
            default:     state_nx = FLAG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            FLAG_RAISED: int_n = 1'b0;
            default:     int_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dpmb_array.sv
module dpmb_array #(
    parameter int ADDR_W = dpmb_pkg::ADDR_W,
    parameter int DATA_W = dpmb_pkg::DATA_W,
    parameter int NPORTS = dpmb_pkg::NPORTS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPORTS-1:0]              wr_en,
    input  logic [NPORTS-1:0]              rd_en,
    input  logic [NPORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [NPORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NPORTS-1:0][DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Highest port index written first, so port 0 (left) lands last and wins.
    always_ff @(posedge clk) begin
        for (int p = NPORTS - 1; p >= 0; p--) begin
            if (wr_en[p]) mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst)           rdata[p] <= '0;
            else if (rd_en[p]) rdata[p] <= mem[addr[p]];
            else               rdata[p] <= '0;
        end
    end
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top
    import dpmb_pkg::*;
#(
    parameter int ADDR_W = dpmb_pkg::ADDR_W,
    parameter int DATA_W = dpmb_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_n,
    output logic              l_int_n,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_n,
    output logic              r_int_n
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int MBOX_LEFT  = DEPTH - 2;
    localparam int MBOX_RIGHT = DEPTH - 1;

    logic [NPORTS-1:0]             ce_n, rw_n, oe_n, busy_n;
    logic [NPORTS-1:0][ADDR_W-1:0] addr;
    logic [NPORTS-1:0][DATA_W-1:0] wdata, rdata;
    logic [NPORTS-1:0]             wr_en, rd_en, raise_peer, ack_own, int_n;

    always_comb begin
        ce_n   = {r_ce_n,   l_ce_n};
        rw_n   = {r_rw_n,   l_rw_n};
        oe_n   = {r_oe_n,   l_oe_n};
        busy_n = {r_busy_n, l_busy_n};
        addr   = {r_addr,   l_addr};
        wdata  = {r_wdata,  l_wdata};
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int OWN  = (p == PORT_L) ? MBOX_LEFT  : MBOX_RIGHT;
        localparam int PEER = (p == PORT_L) ? MBOX_RIGHT : MBOX_LEFT;

        dpmb_port_decode #(
            .ADDR_W(ADDR_W), .OWN_MBOX(OWN), .PEER_MBOX(PEER)
        ) u_dec (
            .ce_n(ce_n[p]), .rw_n(rw_n[p]), .oe_n(oe_n[p]),
            .busy_n(busy_n[p]), .addr(addr[p]),
            .wr_en(wr_en[p]), .rd_en(rd_en[p]),
            .raise_peer(raise_peer[p]), .ack_own(ack_own[p])
        );

        dpmb_flag_fsm u_flag (
            .clk(clk), .rst(rst),
            .raise(raise_peer[NPORTS - 1 - p]),
            .ack(ack_own[p]),
            .int_n(int_n[p])
        );
    end

    dpmb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORTS(NPORTS)) u_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always_comb begin
        l_rdata = rdata[PORT_L];
        r_rdata = rdata[PORT_R];
        l_int_n = int_n[PORT_L];
        r_int_n = int_n[PORT_R];
    end
endmodule

// File: rtl/dpmb_checker.sv
module dpmb_checker #(
    parameter int ADDR_W = dpmb_pkg::ADDR_W,
    parameter int DATA_W = dpmb_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_wdata,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy_n,
    input logic              l_int_n,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_wdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy_n,
    input logic              r_int_n
);
    localparam logic [ADDR_W-1:0] MB_L = ADDR_W'((1 << ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] MB_R = ADDR_W'((1 << ADDR_W) - 1);

    logic set_l, set_r, clr_l, clr_r;
    assign set_l = !r_ce_n && !r_rw_n && r_busy_n && (r_addr == MB_L);
    assign set_r = !l_ce_n && !l_rw_n && l_busy_n && (l_addr == MB_R);
    assign clr_l = !l_ce_n && !l_oe_n && l_busy_n && (l_addr == MB_L);
    assign clr_r = !r_ce_n && !r_oe_n && r_busy_n && (r_addr == MB_R);

    p_set_left_r3: assert property (@(posedge clk) disable iff (rst)
        set_l |=> !l_int_n);
    p_clear_left_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_l && !set_l) |=> l_int_n);
    p_set_right_r5: assert property (@(posedge clk) disable iff (rst)
        set_r |=> !r_int_n);
    p_clear_right_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_r && !set_r) |=> r_int_n);
    p_busy_hold_left_r8: assert property (@(posedge clk) disable iff (rst)
        (!l_busy_n && !set_l) |=> $stable(l_int_n));
    p_fall_needs_set_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(l_int_n) |-> $past(set_l));
    p_idle_data_r2: assert property (@(posedge clk) disable iff (rst)
        (l_ce_n || l_oe_n) |=> (l_rdata == '0));
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (l_int_n && r_int_n && l_rdata == '0 && r_rdata == '0));
endmodule

bind dpmb_top dpmb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpmb_top_tb.sv
module dpmb_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 9;
    localparam int MB_L = 'h7FE;
    localparam int MB_R = 'h7FF;

    logic clk = 0, rst = 1;
    logic l_ce_n = 1, l_rw_n = 1, l_oe_n = 1, l_busy_n = 1;
    logic r_ce_n = 1, r_rw_n = 1, r_oe_n = 1, r_busy_n = 1;
    logic [AW-1:0] l_addr = 0, r_addr = 0;
    logic [DW-1:0] l_wdata = 0, r_wdata = 0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_int_n, r_int_n;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int mem_m [2048];
    int exp_l = 0, exp_r = 0;
    bit flag_l = 0, flag_r = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpmb_top u_dut (.*);

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference, updated at each edge.
    always @(posedge clk) begin
        int rl, rr;
        bit sl, sr, cl, cr;
        cycles++;
        if (rst) begin
            exp_l = 0; exp_r = 0; flag_l = 0; flag_r = 0;
        end else begin
            rl = (!l_ce_n && !l_oe_n) ? mem_m[l_addr] : 0;
            rr = (!r_ce_n && !r_oe_n) ? mem_m[r_addr] : 0;
            sl = !r_ce_n && !r_rw_n && r_busy_n && r_addr == MB_L;
            sr = !l_ce_n && !l_rw_n && l_busy_n && l_addr == MB_R;
            cl = !l_ce_n && !l_oe_n && l_busy_n && l_addr == MB_L;
            cr = !r_ce_n && !r_oe_n && r_busy_n && r_addr == MB_R;
            if (!r_ce_n && !r_rw_n && r_busy_n) mem_m[r_addr] = r_wdata;
            if (!l_ce_n && !l_rw_n && l_busy_n) mem_m[l_addr] = l_wdata;
            exp_l = rl; exp_r = rr;
            flag_l = sl ? 1 : (cl ? 0 : flag_l);
            flag_r = sr ? 1 : (cr ? 0 : flag_r);
        end
    end

    always @(negedge clk) begin
        if (exp_l >= 0) chk("R1 left rdata", l_rdata, exp_l);
        if (exp_r >= 0) chk("R1 right rdata", r_rdata, exp_r);
        chk("R3 left int", l_int_n, !flag_l);
        chk("R5 right int", r_int_n, !flag_r);
    end

    always @(posedge clk) begin
        if (cycles > 50000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(bit right, bit ce, bit rw, bit oe, int a, int d, bit busy);
        if (right) begin
            r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_addr = a[AW-1:0]; r_wdata = d[DW-1:0]; r_busy_n = busy;
        end else begin
            l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_addr = a[AW-1:0]; l_wdata = d[DW-1:0]; l_busy_n = busy;
        end
    endtask

    task automatic idle();
        drive(0, 1, 1, 1, 0, 0, 1);
        drive(1, 1, 1, 1, 0, 0, 1);
    endtask

    task automatic wr(bit right, int a, int d);
        drive(right, 0, 0, 1, a, d, 1); step(); idle();
    endtask

    task automatic rd(bit right, int a);
        drive(right, 0, 1, 0, a, 0, 1); step(); idle();
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem_m[i] = -1;
        repeat (3) step();
        chk("R10 reset l_int_n", l_int_n, 1);
        chk("R10 reset r_int_n", r_int_n, 1);
        chk("R10 reset l_rdata", l_rdata, 0);
        chk("R10 reset r_rdata", r_rdata, 0);
        rst = 0;
        step();

        for (int i = 0; i < 16; i++) wr(0, i, i * 7 + 3);
        for (int i = 16; i < 32; i++) wr(1, i, 'h100 | i);
        for (int i = 0; i < 32; i++) rd(i % 2, i);
        rd(0, 20); chk("R1 left reads right data", l_rdata, 'h114);
        rd(1, 3);  chk("R1 right reads left data", r_rdata, 'h18);

        drive(0, 0, 1, 1, 3, 0, 1); step(); idle();
        chk("R2 oe high gives zero", l_rdata, 0);
        drive(0, 1, 0, 1, 3, 'h1FF, 1); step(); idle();
        rd(0, 3); chk("R2 disabled write ignored", l_rdata, 'h18);

        wr(1, MB_L, 'h1A5);
        chk("R3 left flag set", l_int_n, 0);
        chk("R3 right flag untouched", r_int_n, 1);
        rd(1, MB_L);
        chk("R7 mailbox data", r_rdata, 'h1A5);
        chk("R7 peer read keeps flag", l_int_n, 0);
        drive(0, 0, 1, 1, MB_L, 0, 1); step(); idle();
        chk("R4 oe high no clear", l_int_n, 0);
        rd(0, MB_L);
        chk("R4 read clears", l_int_n, 1);
        chk("R7 owner reads message", l_rdata, 'h1A5);
        wr(1, MB_L, 'h0C3);
        chk("R3 set again", l_int_n, 0);
        drive(0, 0, 0, 0, MB_L, 'h055, 1); step(); idle();
        chk("R4 clear with rw low", l_int_n, 1);
        rd(0, MB_L); chk("R7 mailbox rewritten", l_rdata, 'h055);

        wr(0, MB_R, 'h111);
        chk("R5 right flag set", r_int_n, 0);
        chk("R5 left flag untouched", l_int_n, 1);
        rd(0, MB_R); chk("R6 left read no clear", r_int_n, 0);
        rd(1, MB_R);
        chk("R6 right read clears", r_int_n, 1);
        chk("R6 right reads message", r_rdata, 'h111);

        drive(1, 0, 0, 1, MB_L, 'h0FF, 0); step(); idle();
        chk("R8 busy blocks set", l_int_n, 1);
        rd(0, MB_L); chk("R8 busy blocks store", l_rdata, 'h055);
        wr(1, MB_L, 'h077);
        drive(0, 0, 1, 0, MB_L, 0, 0); step(); idle();
        chk("R8 busy blocks clear", l_int_n, 0);
        rd(0, MB_L); chk("R8 normal clear", l_int_n, 1);
        drive(0, 0, 0, 1, 5, 'h1EE, 0); step(); idle();
        rd(0, 5); chk("R8 busy write dropped", l_rdata, 38);

        drive(1, 0, 0, 1, MB_L, 'h0AB, 1); drive(0, 0, 1, 0, MB_L, 0, 1); step(); idle();
        chk("R9 set wins from idle", l_int_n, 0);
        drive(1, 0, 0, 1, MB_L, 'h0AC, 1); drive(0, 0, 1, 0, MB_L, 0, 1); step(); idle();
        chk("R9 set wins when raised", l_int_n, 0);
        rd(0, MB_L); chk("R9 later clear", l_int_n, 1);

        drive(0, 0, 0, 1, 100, 'h0AA, 1); drive(1, 0, 0, 1, 100, 'h155, 1); step(); idle();
        rd(1, 100); chk("R11 left write wins", r_rdata, 'h0AA);
        drive(0, 0, 0, 1, 10, 'h1C1, 1); drive(1, 0, 1, 0, 10, 0, 1); step(); idle();
        chk("R11 read returns old", r_rdata, 'h49);
        rd(1, 10); chk("R11 new data after", r_rdata, 'h1C1);

        wr(1, MB_L, 1); wr(0, MB_R, 2);
        drive(0, 0, 1, 0, 1, 0, 1);
        rst = 1; step(); idle();
        chk("R10 mid reset l_int_n", l_int_n, 1);
        chk("R10 mid reset r_int_n", r_int_n, 1);
        chk("R10 mid reset rdata", l_rdata, 0);
        rst = 0; step();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule